// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits between a local bus and a PCI master. It turns each local-bus address into a PCI bus address through a small set of programmable windows. Each window has a base register and a map register. The base register gives the local start address, a span code, an enable bit and a prefetchable flag. The map register gives the PCI start address, a three-bit cycle-type code and a low-bit select. The block reports the matching window's translation one clock after it samples the address, together with the cycle type and the prefetchable attribute.

Windows may overlap. When they do, the enabled window with the smallest index decides the result. Software relies on this to borrow a window for configuration accesses. It first widens window 0 so that window 0 covers the span that window 1 normally serves. It then points window 1 at configuration space. The last window is reserved for PCI I/O and has a fixed 16 MB span. For configuration cycles, the low two PCI address bits either come from the local address or are forced to zero, as the map register selects.

Top module: `lbus_pci_xlat`

## Requirements
- R1: After reset, every register reads back zero and all translation outputs (`xl_hit`, `xl_miss`, `xl_addr`, `xl_cyc`, `xl_pref`) are zero.
- R2: Register index 2w is the base register of window w and index 2w+1 is its map register. A write is visible on `cfg_rdata` from the clock edge that accepts it. Writes to indices 6 and 7 change nothing, and those indices read zero.
- R3: A window takes part in matching only while bit 0 (enable) of its base register is 1.
- R4: Base bits [7:4] hold a span code c, and the window spans 1 MB shifted left by c. Codes above 9 mean 512 MB, so code 4 is 16 MB and code 8 is 256 MB. Base bits [31:20] give the local start, and any of those bits that fall below the span are ignored.
- R5: The last window (index 2) always spans 16 MB whatever its span code, and it never reports prefetchable.
- R6: When several enabled windows contain the address, the one with the lowest index supplies the result.
- R7: On a hit, the address bits above the span come from map bits [31:20], and the bits below the span come from the local address.
- R8: For windows 0 and 1, `xl_pref` on a hit equals bit 1 of the selected base register.
- R9: `xl_cyc` equals map bits [3:1]. When that code is 3'b101 (configuration) and map bit 0 is 0, PCI address bits [1:0] are 00. In every other case they copy the local address.
- R10: When no window matches, `xl_miss` is 1 and `xl_hit`, `xl_addr`, `xl_cyc` and `xl_pref` are 0. `xl_hit` and `xl_miss` are never 1 together.
- R11: The outputs reflect `lb_addr` as sampled at the previous clock edge, translated with the register contents that held before that edge. A register write accepted at the same edge does not affect that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the indexed register |
| lb_addr | input | 32 | Local-bus address to translate |
| xl_hit | output | 1 | A window matched |
| xl_miss | output | 1 | No window matched |
| xl_addr | output | 32 | Translated PCI address |
| xl_cyc | output | 3 | Cycle-type code of the selected window |
| xl_pref | output | 1 | Prefetchable attribute of the selected window |

## Verification
The hardest case to reach from the ports is the window swap used for configuration access. Window 0 is widened so that it shadows window 1's span, and window 1 is then moved onto configuration space, possibly on top of the I/O window. The stimulus steps through that register sequence. At each step it probes an address inside the shadowed region, then disables window 0 so that the same address falls through to window 1. This exposes both the priority order and the low-bit forcing of configuration cycles. A further case writes a base register in the same cycle that a lookup is sampled, to show that the lookup still uses the previous register contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XW        = 32;
  localparam int GRAN_LOG2 = 20;
  localparam int HI_W      = XW - GRAN_LOG2;
  localparam int CODE_W    = 4;
  localparam int CODE_LSB  = 4;
  localparam int MAX_CODE  = 9;
  localparam int CYC_W     = 3;
  localparam int CYC_LSB   = 1;
  localparam int BIT_EN    = 0;
  localparam int BIT_PF    = 1;
  localparam int BIT_LOW   = 0;
  localparam logic [CYC_W-1:0] CYC_CONFIG = 3'b101;

  typedef struct packed {
    logic              en;
    logic              pf;
    logic [HI_W-1:0]   lbase;
    logic [CODE_W-1:0] code;
  } base_f_t;

  typedef struct packed {
    logic [HI_W-1:0]  pbase;
    logic [CYC_W-1:0] cyc;
    logic             lowsel;
  } map_f_t;

  function automatic base_f_t unpack_base(input logic [XW-1:0] r);
    base_f_t f;
    f.en    = r[BIT_EN];
    f.pf    = r[BIT_PF];
    f.lbase = r[XW-1:GRAN_LOG2];
    f.code  = r[CODE_LSB +: CODE_W];
    return f;
  endfunction

  function automatic map_f_t unpack_map(input logic [XW-1:0] r);
    map_f_t f;
    f.pbase  = r[XW-1:GRAN_LOG2];
    f.cyc    = r[CYC_LSB +: CYC_W];
    f.lowsel = r[BIT_LOW];
    return f;
  endfunction

  // Mask over the upper address field: ones mark bits that select the window.
  function automatic logic [HI_W-1:0] span_mask(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    return {HI_W{1'b1}} << c;
  endfunction

  function automatic logic in_window(input logic [HI_W-1:0] la_hi,
                                     input logic [HI_W-1:0] lbase,
                                     input logic [HI_W-1:0] mask);
    return ((la_hi ^ lbase) & mask) == '0;
  endfunction

  function automatic logic [XW-1:0] remap(input logic [XW-1:0]    la,
                                          input logic [HI_W-1:0]  pbase,
                                          input logic [HI_W-1:0]  mask,
                                          input logic [CYC_W-1:0] cyc,
                                          input logic             lowsel);
    logic [XW-1:0] a;
    a = {(pbase & mask) | (la[XW-1:GRAN_LOG2] & ~mask), la[GRAN_LOG2-1:0]};
    if (cyc == CYC_CONFIG && !lowsel) a[1:0] = 2'b00;
    return a;
  endfunction
endpackage

// File: rtl/xlat_regbank.sv
module xlat_regbank
  import xlat_pkg::*;
#(
  parameter int NWIN = 3,
  parameter int IDX_W = $clog2(2*NWIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [XW-1:0]            wr_data,
  output logic [XW-1:0]            rd_data,
  output logic [NWIN-1:0][XW-1:0]  base_o,
  output logic [NWIN-1:0][XW-1:0]  map_o
);
  localparam int NREG = 2*NWIN;

  logic [NREG-1:0][XW-1:0] regs_q;
  logic                    idx_ok;

  assign idx_ok = int'(idx) < NREG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en && idx_ok) begin
      for (int i = 0; i < NREG; i++)
        if (int'(idx) == i) regs_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(idx) == i) rd_data = regs_q[i];
  end

  for (genvar gw = 0; gw < NWIN; gw++) begin : g_out
    assign base_o[gw] = regs_q[2*gw];
    assign map_o[gw]  = regs_q[2*gw+1];
  end

  // R2: an accepted write lands in the addressed register
  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_ok) |=> (regs_q[$past(idx)] == $past(wr_data)));

  // R2: writes outside the register range leave every register unchanged
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idx_ok) |=> $stable(regs_q));
endmodule

// File: rtl/xlat_window_match.sv
module xlat_window_match
  import xlat_pkg::*;
#(
  parameter bit FIXED_SPAN  = 1'b0,
  parameter int FIXED_CODE  = 4,
  parameter bit NO_PREFETCH = 1'b0
) (
  input  logic [XW-1:0]    base_raw,
  input  logic [XW-1:0]    map_raw,
  input  logic [XW-1:0]    lb_addr,
  output logic             match,
  output logic             en,
  output logic [XW-1:0]    cand_addr,
  output logic [CYC_W-1:0] cand_cyc,
  output logic             cand_pf,
  output logic             cand_low
);
  base_f_t         bf;
  map_f_t          mf;
  logic [HI_W-1:0] mask;
  logic            in_rng;

  always_comb begin
    bf     = unpack_base(base_raw);
    mf     = unpack_map(map_raw);
    mask   = FIXED_SPAN ? span_mask(CODE_W'(FIXED_CODE)) : span_mask(bf.code);
    in_rng = in_window(lb_addr[XW-1:GRAN_LOG2], bf.lbase, mask);
  end

  assign en        = bf.en;
  assign match     = bf.en && in_rng;
  assign cand_addr = remap(lb_addr, mf.pbase, mask, mf.cyc, mf.lowsel);
  assign cand_cyc  = mf.cyc;
  assign cand_pf   = NO_PREFETCH ? 1'b0 : bf.pf;
  assign cand_low  = mf.lowsel;
endmodule

// File: rtl/xlat_prio_select.sv
module xlat_prio_select
  import xlat_pkg::*;
#(
  parameter int NWIN = 3
) (
  input  logic [NWIN-1:0]             match,
  input  logic [NWIN-1:0][XW-1:0]     c_addr,
  input  logic [NWIN-1:0][CYC_W-1:0]  c_cyc,
  input  logic [NWIN-1:0]             c_pf,
  input  logic [NWIN-1:0]             c_low,
  output logic                        any,
  output logic [NWIN-1:0]             sel_oh,
  output logic [XW-1:0]               addr,
  output logic [CYC_W-1:0]            cyc,
  output logic                        pf,
  output logic                        lowsel
);
  always_comb begin
    sel_oh = '0;
    any    = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (match[i] && !any) begin
        sel_oh[i] = 1'b1;
        any       = 1'b1;
      end
    end
  end

  always_comb begin
    addr   = '0;
    cyc    = '0;
    pf     = 1'b0;
    lowsel = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (sel_oh[i]) begin
        addr   = addr | c_addr[i];
        cyc    = cyc | c_cyc[i];
        pf     = pf | c_pf[i];
        lowsel = lowsel | c_low[i];
      end
    end
  end
endmodule

// File: rtl/lbus_pci_xlat.sv
module lbus_pci_xlat
  import xlat_pkg::*;
#(
  parameter int NWIN    = 3,
  parameter int IO_WIN  = 2,
  parameter int IO_CODE = 4,
  parameter int IDX_W   = $clog2(2*NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [XW-1:0]    cfg_wdata,
  output logic [XW-1:0]    cfg_rdata,
  input  logic [XW-1:0]    lb_addr,
  output logic             xl_hit,
  output logic             xl_miss,
  output logic [XW-1:0]    xl_addr,
  output logic [CYC_W-1:0] xl_cyc,
  output logic             xl_pref
);
  logic [NWIN-1:0][XW-1:0]    base_w, map_w;
  logic [NWIN-1:0]            match_vec, en_vec, c_pf, c_low;
  logic [NWIN-1:0][XW-1:0]    c_addr;
  logic [NWIN-1:0][CYC_W-1:0] c_cyc;
  logic                       any;
  logic [NWIN-1:0]            sel_oh;
  logic [XW-1:0]              s_addr;
  logic [CYC_W-1:0]           s_cyc;
  logic                       s_pf, s_low;
  logic [NWIN-1:0]            sel_q;
  logic                       low_q;

  xlat_regbank #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .idx(cfg_idx), .wr_data(cfg_wdata),
    .rd_data(cfg_rdata), .base_o(base_w), .map_o(map_w)
  );

  for (genvar gw = 0; gw < NWIN; gw++) begin : g_win
    if (gw == IO_WIN) begin : g_io
      xlat_window_match #(.FIXED_SPAN(1'b1), .FIXED_CODE(IO_CODE), .NO_PREFETCH(1'b1)) u_m (
        .base_raw(base_w[gw]), .map_raw(map_w[gw]), .lb_addr(lb_addr),
        .match(match_vec[gw]), .en(en_vec[gw]), .cand_addr(c_addr[gw]),
        .cand_cyc(c_cyc[gw]), .cand_pf(c_pf[gw]), .cand_low(c_low[gw])
      );
    end else begin : g_mem
      xlat_window_match #(.FIXED_SPAN(1'b0), .FIXED_CODE(IO_CODE), .NO_PREFETCH(1'b0)) u_m (
        .base_raw(base_w[gw]), .map_raw(map_w[gw]), .lb_addr(lb_addr),
        .match(match_vec[gw]), .en(en_vec[gw]), .cand_addr(c_addr[gw]),
        .cand_cyc(c_cyc[gw]), .cand_pf(c_pf[gw]), .cand_low(c_low[gw])
      );
    end
  end

  xlat_prio_select #(.NWIN(NWIN)) u_sel (
    .match(match_vec), .c_addr(c_addr), .c_cyc(c_cyc), .c_pf(c_pf), .c_low(c_low),
    .any(any), .sel_oh(sel_oh), .addr(s_addr), .cyc(s_cyc), .pf(s_pf), .lowsel(s_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_hit  <= 1'b0;
      xl_miss <= 1'b0;
      xl_addr <= '0;
      xl_cyc  <= '0;
      xl_pref <= 1'b0;
      sel_q   <= '0;
      low_q   <= 1'b0;
    end else begin
      xl_hit  <= any;
      xl_miss <= !any;
      xl_addr <= any ? s_addr : '0;
      xl_cyc  <= any ? s_cyc : '0;
      xl_pref <= any && s_pf;
      sel_q   <= sel_oh;
      low_q   <= s_low;
    end
  end

  // R10: hit and miss exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_hit && xl_miss));

  // R10: a miss carries no translation
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_addr == '0 && xl_cyc == '0 && !xl_pref));

  // R3: the reported window was enabled when the address was sampled
  p_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> (($past(en_vec) & sel_q) != '0));

  // R6: no lower-indexed window matched the sampled address
  p_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_hit |-> (($past(match_vec) & (sel_q - NWIN'(1))) == '0));

  // R6: exactly one window selected on a hit, none on a miss
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q) && (xl_hit == (sel_q != '0)));

  // R9: configuration cycles with cleared low select force A[1:0] to zero
  p_cfg_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && xl_cyc == CYC_CONFIG && !low_q) |-> (xl_addr[1:0] == 2'b00));

  if (IO_WIN < NWIN) begin : g_io_chk
    // R5: the I/O window never reports prefetchable
    p_io_nopf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_hit && sel_q[IO_WIN]) |-> !xl_pref);
  end
endmodule

// File: tb/sim_lbus_pci_xlat.sv
`timescale 1ns/1ps
module sim_lbus_pci_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lb_addr = '0;
  wire  [31:0] cfg_rdata;
  wire         xl_hit, xl_miss, xl_pref;
  wire  [31:0] xl_addr;
  wire  [2:0]  xl_cyc;

  always #2 clk = ~clk;

  lbus_pci_xlat u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lb_addr(lb_addr), .xl_hit(xl_hit), .xl_miss(xl_miss),
    .xl_addr(xl_addr), .xl_cyc(xl_cyc), .xl_pref(xl_pref)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] sh_base [3];
  logic [31:0] sh_map  [3];

  typedef struct packed {
    logic [31:0] la;
    logic        hit;
    logic [31:0] pa;
    logic [2:0]  cyc;
    logic        pf;
  } vec_t;

  // Stimulus and expectations for the standard three-window setup.
  localparam vec_t [0:6] VT = '{
    '{32'h41234567, 1'b1, 32'h01234567, 3'd3, 1'b0},
    '{32'h5ABCDEF3, 1'b1, 32'h1ABCDEF3, 3'd7, 1'b1},
    '{32'h60FFFFFF, 1'b1, 32'h00FFFFFF, 3'd1, 1'b0},
    '{32'h61000000, 1'b0, 32'h00000000, 3'd0, 1'b0},
    '{32'h3FFFFFFC, 1'b0, 32'h00000000, 3'd0, 1'b0},
    '{32'h4FFFFFFF, 1'b1, 32'h0FFFFFFF, 3'd3, 1'b0},
    '{32'h50000000, 1'b1, 32'h10000000, 3'd7, 1'b1}
  };

  function automatic logic [63:0] pack_res(logic h, logic [31:0] a, logic [2:0] c, logic p);
    return {26'd0, h, !h, a, c, p};
  endfunction

  function automatic logic [63:0] got();
    return {26'd0, xl_hit, xl_miss, xl_addr, xl_cyc, xl_pref};
  endfunction

  // Range model in wide arithmetic: first enabled window containing the address.
  function automatic logic [63:0] model(logic [31:0] la);
    for (int w = 0; w < 3; w++) begin
      logic [63:0] size, lb, pb, a64;
      int c;
      if (sh_base[w][0]) begin
        c = (w == 2) ? 4 : int'(sh_base[w][7:4]);
        if (c > 9) c = 9;
        size = 64'd1 << (20 + c);
        lb = {32'd0, sh_base[w][31:20], 20'd0};
        lb = lb - (lb % size);
        if ({32'd0, la} >= lb && {32'd0, la} < lb + size) begin
          pb = {32'd0, sh_map[w][31:20], 20'd0};
          pb = pb - (pb % size);
          a64 = pb + ({32'd0, la} - lb);
          if (sh_map[w][3:1] == 3'b101 && !sh_map[w][0]) a64[1:0] = 2'b00;
          return pack_res(1'b1, a64[31:0], sh_map[w][3:1], (w == 2) ? 1'b0 : sh_base[w][1]);
        end
      end
    end
    return pack_res(1'b0, 32'd0, 3'd0, 1'b0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx < 6) begin
      if (idx % 2 == 0) sh_base[idx/2] = d; else sh_map[idx/2] = d;
    end
  endtask

  task automatic rd(input string req, input int idx, input logic [31:0] exp);
    cfg_idx = idx[2:0];
    #1;
    chk(req, {32'd0, cfg_rdata}, {32'd0, exp});
    @(posedge clk); #1;
  endtask

  task automatic look(input string req, input logic [31:0] la);
    logic [63:0] e;
    lb_addr = la;
    e = model(la);
    @(posedge clk); #1;
    chk(req, got(), e);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin sh_base[w] = '0; sh_map[w] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state of outputs and registers
    chk("R1 outputs in reset", got(), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) rd("R1 register zero", i, 32'd0);

    // Standard setup: two 256 MB memory windows and the I/O window.
    wr(0, 32'h40000081);
    wr(1, 32'h00000006);
    wr(2, 32'h50000083);
    wr(3, 32'h1000000E);
    wr(4, 32'h60000001);
    wr(5, 32'h00000002);
    rd("R2 readback base1", 2, 32'h50000083);
    rd("R2 readback map2", 5, 32'h00000002);
    wr(6, 32'hDEADBEEF);
    rd("R2 index 6 reads zero", 6, 32'd0);
    rd("R2 base0 untouched by index 6", 0, 32'h40000081);

    // R7 R8 R10: table walk
    for (int v = 0; v < 7; v++) begin
      lb_addr = VT[v].la;
      @(posedge clk); #1;
      chk($sformatf("R7 R8 R10 table vector %0d", v), got(),
          pack_res(VT[v].hit, VT[v].pa, VT[v].cyc, VT[v].pf));
    end

    // R3: disabled window stops matching
    wr(2, 32'h50000082);
    look("R3 disabled window misses", 32'h50000000);
    wr(2, 32'h50000083);
    look("R3 re-enabled window hits", 32'h50000000);

    // R11: write at the same edge as a lookup does not affect it
    begin
      logic [63:0] e_old;
      lb_addr = 32'h41234567;
      e_old = model(32'h41234567);
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'h40000080;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      sh_base[0] = 32'h40000080;
      chk("R11 lookup uses old registers", got(), e_old);
      @(posedge clk); #1;
      chk("R11 next lookup sees write", got(), model(32'h41234567));
    end

    // Configuration swap: window 0 widened to 512 MB, window 1 on config space.
    wr(0, 32'h40000091);
    wr(2, 32'h61000041);
    wr(3, 32'h0000000A);
    look("R4 512 MB span top", 32'h5FFFFFF0);
    look("R9 config low bits forced", 32'h61234567);
    wr(3, 32'h0000000B);
    look("R9 config low bits passed", 32'h61234567);

    // R5: I/O window ignores span code and prefetch flag
    wr(4, 32'h60000093);
    look("R5 beyond 16 MB misses", 32'h62000000);
    look("R5 hit without prefetch", 32'h60000004);

    // R6: overlapping windows
    wr(2, 32'h50000041);
    look("R6 window 0 shadows window 1", 32'h50000002);
    wr(0, 32'h40000090);
    look("R6 window 1 after window 0 off", 32'h50000002);
    wr(2, 32'h60000041);
    look("R6 window 1 over I/O window", 32'h60000010);

    // R4: code above 9 clamps to 512 MB, misaligned base bits ignored
    wr(0, 32'h488000F1);
    look("R4 clamped misaligned span", 32'h50000008);
    look("R4 below span misses", 32'h3FF00000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule